// File: doc/BRIEF.md
# Polled / Interrupt-Driven I/O Port Register Block

This block is a small peripheral that a processor reaches through four 16-bit registers at fixed bus addresses. It has one inbound channel and one outbound channel, and each follows a three-step handshake: software prepares, then waits, then completes.

On the inbound side a device-side strobe delivers a word. The block latches the word into the input data register and sets a ready flag. Software reads the word and then writes the ready flag back to zero. If a second word arrives before that completion step, the second word is discarded and a sticky overrun flag records the loss.

On the outbound side software loads the output data register and sets a start bit. The block models a slow device: it stays busy for a parameterised number of clock cycles and then presents the word on its device-side output for one cycle. It then sets a done flag, which software completes by clearing the control register. Software can poll either channel's status, or enable that channel to drive a level interrupt request that stays asserted until the completion step.

Top module: `mmio_port`

## Requirements
- R1: After synchronous reset every register reads as zero, and `irq`, `bus_rdata` and `dev_out_valid` are 0.
- R2: The map sits at BASE (default 0xFF00), with registers two bytes apart: +0 input data (read-only), +2 input control, +4 output data, +6 output control. A read returns its data on `bus_rdata` one cycle after `bus_rd`. `bus_rdata` is zero in any cycle that does not follow a read, and a read of an unmapped address returns zero.
- R3: When `dev_in_valid` is pulsed while input control bit 0 (ready) is 0, the input data register takes `dev_in_word` and bit 0 reads 1.
- R4: A write to input control clears ready when bit 0 of the written value is 0. Writing 1 to bit 0 never sets ready.
- R5: When a word arrives while ready is 1, the word is dropped, the input data register keeps the old word, and input control bit 2 (overrun) is set. Overrun stays set until a write to input control has bit 2 equal to 0.
- R6: When output control is idle (bits 0 and 1 both 0), writing it with bit 0 = 1 starts a transfer. For XFER_CYCLES cycles bit 0 (busy/start) reads 1 and bit 1 (done) reads 0.
- R7: At the end of the transfer, start drops to 0 and done rises to 1 on the same edge. In that cycle `dev_out_valid` is high for exactly one cycle, with `dev_out_word` equal to the output data register.
- R8: While a transfer is busy, writes to the output data register and to output control are ignored.
- R9: Writing output control with bit 1 = 0 clears done. A start request in a write that leaves done set is ignored.
- R10: Input control bit 3 and output control bit 2 are interrupt enables. `irq` is registered: one cycle after (ready AND input enable) OR (done AND output enable) holds, it goes high, and it stays high until the matching completion step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read request, data follows one cycle later |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, zero when not reading |
| dev_in_valid | input | 1 | Device-side strobe delivering a new input word |
| dev_in_word | input | DATA_W | Incoming word |
| dev_out_valid | output | 1 | One-cycle pulse when an output transfer completes |
| dev_out_word | output | DATA_W | Word being transferred out |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest behaviour to reach from the ports is how the block treats bus writes that land in the middle of a running output transfer, and start requests that arrive while done is still pending. If those were accepted by mistake, a transfer could restart or be corrupted. The stimulus starts a transfer and, within its busy window, issues back-to-back writes of a new data word and a zeroed control value. It then measures the cycle count to `dev_out_valid` and the word carried there. A separate scenario stacks a second input word on top of an unread one to force the overrun path. It then clears ready and overrun in two separate writes, to show that each flag clears independently.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;
  localparam int unsigned OFF_IN_DATA  = 0;
  localparam int unsigned OFF_IN_CTL   = 2;
  localparam int unsigned OFF_OUT_DATA = 4;
  localparam int unsigned OFF_OUT_CTL  = 6;

  // input control bits
  localparam int unsigned IN_RDY_BIT = 0;
  localparam int unsigned IN_OVR_BIT = 2;
  localparam int unsigned IN_IE_BIT  = 3;

  // output control bits
  localparam int unsigned OUT_GO_BIT   = 0;
  localparam int unsigned OUT_DONE_BIT = 1;
  localparam int unsigned OUT_IE_BIT   = 2;
endpackage

// File: rtl/mmio_rx_chan.sv
module mmio_rx_chan
  import mmio_port_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_word,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              ovr_q,
  output logic              ie_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      if (ctl_we) begin
        ready_q <= ready_q & wdata[IN_RDY_BIT];
        ovr_q   <= ovr_q & wdata[IN_OVR_BIT];
        ie_q    <= wdata[IN_IE_BIT];
      end
      if (in_valid) begin
        if (!ready_q) begin
          data_q  <= in_word;
          ready_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ready_q) |=> (ready_q && data_q == $past(in_word)));

  p_drop_keeps_word_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ready_q) |=> (ovr_q && $stable(data_q)));

  p_ready_never_self_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && !in_valid) |=> !ready_q);
endmodule

// File: rtl/mmio_tx_chan.sv
module mmio_tx_chan
  import mmio_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int XFER_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word,
  output logic [DATA_W-1:0] dout_q,
  output logic              go_q,
  output logic              done_q,
  output logic              ie_q
);
  localparam int CNT_W = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy;
  logic             done_keep;

  assign busy      = go_q && !done_q;
  assign done_keep = done_q & wdata[OUT_DONE_BIT];
  assign out_word  = dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q    <= '0;
      go_q      <= 1'b0;
      done_q    <= 1'b0;
      ie_q      <= 1'b0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        if (cnt_q == '0) begin
          go_q      <= 1'b0;
          done_q    <= 1'b1;
          out_valid <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        if (dat_we) dout_q <= wdata;
        if (ctl_we) begin
          done_q <= done_keep;
          ie_q   <= wdata[OUT_IE_BIT];
          go_q   <= wdata[OUT_GO_BIT] & ~done_keep;
          cnt_q  <= CNT_LAST;
        end
      end
    end
  end

  p_go_done_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(go_q && done_q));

  p_done_with_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> out_valid);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_busy_holds_word_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && dat_we) |=> $stable(dout_q));
endmodule

// File: rtl/mmio_port.sv
module mmio_port
  import mmio_port_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 16,
  parameter logic [15:0]     BASE        = 16'hFF00,
  parameter int              XFER_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_word,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_word,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_IN_DATA  = ADDR_W'(BASE + OFF_IN_DATA);
  localparam logic [ADDR_W-1:0] A_IN_CTL   = ADDR_W'(BASE + OFF_IN_CTL);
  localparam logic [ADDR_W-1:0] A_OUT_DATA = ADDR_W'(BASE + OFF_OUT_DATA);
  localparam logic [ADDR_W-1:0] A_OUT_CTL  = ADDR_W'(BASE + OFF_OUT_CTL);

  logic [DATA_W-1:0] rx_data, tx_data, rd_mux;
  logic rx_ready, rx_ovr, rx_ie;
  logic tx_go, tx_done, tx_ie;
  logic irq_next;

  mmio_rx_chan #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .in_valid (dev_in_valid),
    .in_word  (dev_in_word),
    .ctl_we   (bus_wr && bus_addr == A_IN_CTL),
    .wdata    (bus_wdata),
    .data_q   (rx_data),
    .ready_q  (rx_ready),
    .ovr_q    (rx_ovr),
    .ie_q     (rx_ie)
  );

  mmio_tx_chan #(.DATA_W(DATA_W), .XFER_CYCLES(XFER_CYCLES)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .dat_we    (bus_wr && bus_addr == A_OUT_DATA),
    .ctl_we    (bus_wr && bus_addr == A_OUT_CTL),
    .wdata     (bus_wdata),
    .out_valid (dev_out_valid),
    .out_word  (dev_out_word),
    .dout_q    (tx_data),
    .go_q      (tx_go),
    .done_q    (tx_done),
    .ie_q      (tx_ie)
  );

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_IN_DATA:  rd_mux = rx_data;
      A_IN_CTL: begin
        rd_mux[IN_RDY_BIT] = rx_ready;
        rd_mux[IN_OVR_BIT] = rx_ovr;
        rd_mux[IN_IE_BIT]  = rx_ie;
      end
      A_OUT_DATA: rd_mux = tx_data;
      A_OUT_CTL: begin
        rd_mux[OUT_GO_BIT]   = tx_go;
        rd_mux[OUT_DONE_BIT] = tx_done;
        rd_mux[OUT_IE_BIT]   = tx_ie;
      end
      default:    rd_mux = '0;
    endcase
  end

  assign irq_next = (rx_ready && rx_ie) || (tx_done && tx_ie);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      irq       <= irq_next;
    end
  end

  p_rdata_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && rx_ie) |=> irq);

  p_irq_needs_source_r10: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && !tx_done) |=> !irq);
endmodule

// File: tb/mmio_port_bench.sv
module mmio_port_bench;
  localparam int LAT = 16;
  localparam logic [15:0] B = 16'hFF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dev_in_valid = 1'b0;
  logic [15:0] dev_in_word = '0;
  logic        dev_out_valid;
  logic [15:0] dev_out_word;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mmio_port #(.XFER_CYCLES(LAT)) u_mmio_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_in_valid(dev_in_valid),
    .dev_in_word(dev_in_word), .dev_out_valid(dev_out_valid),
    .dev_out_word(dev_out_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [15:0] w);
    dev_in_word = w; dev_in_valid = 1'b1;
    @(negedge clk);
    dev_in_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 out_valid", {15'd0, dev_out_valid}, 16'd0);
    chk("R1 rdata", bus_rdata, 16'd0);
    for (int i = 0; i < 4; i++) begin
      rd(B + 16'(2 * i), v);
      chk("R1 reg", v, 16'd0);
    end
  endtask

  task automatic t_bus();
    logic [15:0] v;
    wr(B + 16'd4, 16'hBEEF);
    rd(B + 16'd4, v);
    chk("R2 out data readback", v, 16'hBEEF);
    @(negedge clk);
    chk("R2 idle rdata zero", bus_rdata, 16'd0);
    rd(B + 16'd8, v);
    chk("R2 unmapped", v, 16'd0);
    rd(16'h0004, v);
    chk("R2 off-base", v, 16'd0);
  endtask

  task automatic t_input();
    logic [15:0] v;
    wr(B + 16'd2, 16'h0001);
    rd(B + 16'd2, v);
    chk("R4 write1 no set", v, 16'd0);
    push(16'h1234);
    rd(B + 16'd2, v);
    chk("R3 ready", v, 16'h0001);
    rd(B, v);
    chk("R3 word", v, 16'h1234);
    wr(B + 16'd2, 16'h0000);
    rd(B + 16'd2, v);
    chk("R4 cleared", v, 16'd0);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    push(16'hAAAA);
    push(16'h5555);
    rd(B, v);
    chk("R5 kept word", v, 16'hAAAA);
    rd(B + 16'd2, v);
    chk("R5 ovr set", v, 16'h0005);
    wr(B + 16'd2, 16'h0004);
    rd(B + 16'd2, v);
    chk("R5 ovr sticky", v, 16'h0004);
    wr(B + 16'd2, 16'h0000);
    rd(B + 16'd2, v);
    chk("R5 ovr cleared", v, 16'h0000);
    push(16'h7777);
    rd(B, v);
    chk("R3 after ovr", v, 16'h7777);
    wr(B + 16'd2, 16'h0000);
  endtask

  task automatic t_output();
    logic [15:0] v;
    int k;
    wr(B + 16'd4, 16'hC0DE);
    wr(B + 16'd6, 16'h0001);
    rd(B + 16'd6, v);
    chk("R6 busy", v, 16'h0001);
    k = 1;
    while (!dev_out_valid && k < 1000) begin @(negedge clk); k++; end
    chk("R6 latency", 16'(k), 16'(LAT));
    chk("R7 word", dev_out_word, 16'hC0DE);
    @(negedge clk);
    chk("R7 pulse single", {15'd0, dev_out_valid}, 16'd0);
    rd(B + 16'd6, v);
    chk("R7 done", v, 16'h0002);
    wr(B + 16'd6, 16'h0003);
    rd(B + 16'd6, v);
    chk("R9 start ignored while done", v, 16'h0002);
    wr(B + 16'd6, 16'h0000);
    rd(B + 16'd6, v);
    chk("R9 cleared", v, 16'h0000);
  endtask

  task automatic t_busy_writes();
    logic [15:0] v;
    int k;
    wr(B + 16'd4, 16'h1111);
    wr(B + 16'd6, 16'h0001);
    wr(B + 16'd4, 16'h2222);
    wr(B + 16'd6, 16'h0000);
    k = 2;
    while (!dev_out_valid && k < 1000) begin @(negedge clk); k++; end
    chk("R8 latency unchanged", 16'(k), 16'(LAT));
    chk("R8 word kept", dev_out_word, 16'h1111);
    wr(B + 16'd6, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(B + 16'd2, 16'h0008);
    push(16'h0042);
    chk("R10 irq lag", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R10 irq rx", {15'd0, irq}, 16'd1);
    wr(B + 16'd2, 16'h0008);
    @(negedge clk);
    chk("R10 irq rx cleared", {15'd0, irq}, 16'd0);
    wr(B + 16'd2, 16'h0000);
    wr(B + 16'd6, 16'h0005);
    repeat (LAT + 2) @(negedge clk);
    chk("R10 irq tx", {15'd0, irq}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R10 irq held", {15'd0, irq}, 16'd1);
    wr(B + 16'd6, 16'h0000);
    @(negedge clk);
    chk("R10 irq tx cleared", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bus();
    t_input();
    t_overrun();
    t_output();
    t_busy_writes();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule